// File: doc/BRIEF.md
# Disjoint Routing Switch Box with Optional Output Pipelining

This block is the routing switch of one tile in a coarse-grained reconfigurable array. It has four sides (north, south, east, west). Each side has `NUM_TRACKS` incoming and `NUM_TRACKS` outgoing data lanes, and each lane is `DATA_W` bits wide. Connectivity is disjoint: an outgoing lane can only be fed from the same track number on one of the three other sides. A small per-output select register picks which of those three sources reaches the output.

When the `PIPELINE` parameter is set, every output also has a register. A one-bit per-output mode register chooses between the combinational route and the registered copy of it. All select and mode registers sit behind a simple configuration port with an 8-bit address and 32-bit data. Writes are synchronous, and readback is combinational from the presented address. A fabric loader writes the routing once and then streams data through the lanes.

Lanes are flattened onto wide vectors. Lane number `o = side*NUM_TRACKS + track` occupies bits `[o*DATA_W +: DATA_W]`, with side codes north=0, south=1, east=2, west=3.

Top module: `sb_disjoint_switch`

## Requirements
- R1: An active-low asynchronous reset clears every route select, every mode bit and every output register to 0. After reset, every configuration address reads back 0.
- R2: The route select of output lane (side s, track t) picks a source among the other three sides, taken in ascending side-code order. Value 0 picks the lowest remaining side code, value 1 the next and value 2 the highest. The source is always track t of the chosen side.
- R3: A route select value of 3 drives the output lane to all zeros.
- R4: With its mode bit at 0, an output lane follows its selected input combinationally, in the same cycle.
- R5: With its mode bit at 1, an output lane shows the value its route produced at the previous rising clock edge.
- R6: Route select registers sit at addresses 0 to 4*NUM_TRACKS-1, with address = side*NUM_TRACKS + track. A write stores data bits [1:0] and discards the rest. Readback returns the stored value zero-extended to 32 bits.
- R7: When `PIPELINE` is 1, mode bits sit at addresses 4*NUM_TRACKS to 8*NUM_TRACKS-1, in the same lane order as R6. A write stores data bit 0, and readback returns it zero-extended.
- R8: A write to any address outside the mapped range changes no register. Such an address reads back 0.
- R9: A write takes effect at the rising clock edge where the write enable is high, and readback shows the new value right after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write enable |
| cfgAddr | input | 8 | Configuration address |
| cfgWdata | input | 32 | Configuration write data |
| cfgRdata | output | 32 | Readback of the addressed register |
| sbIn | input | 4*NUM_TRACKS*DATA_W | Incoming lanes, lane o at [o*DATA_W +: DATA_W] |
| sbOut | output | 4*NUM_TRACKS*DATA_W | Outgoing lanes, same layout |

## Verification
A corrupted route select shows in the same cycle, as the wrong neighbour's data or zeros on exactly one output lane, and also as a wrong readback value at its address. A stuck or misdecoded mode bit shows as a lane that is one cycle late or one cycle early, but only when the input changes between edges. The stimulus therefore changes inputs every cycle. A write that lands on the wrong register is visible right after the edge, both on readback of the intended address and of the hit address.

// File: rtl/sb_pkg.sv
`timescale 1ns/1ps
package sb_pkg;
  localparam int CFG_ADDR_W = 8;
  localparam int CFG_DATA_W = 32;
  localparam int NUM_SIDES  = 4;
  localparam int SEL_W      = 2;

  typedef enum logic [1:0] {
    SIDE_NORTH = 2'd0,
    SIDE_SOUTH = 2'd1,
    SIDE_EAST  = 2'd2,
    SIDE_WEST  = 2'd3
  } side_e;

  typedef struct packed {
    logic                  routeWe;
    logic                  modeWe;
    logic                  hitRoute;
    logic                  hitMode;
    logic [CFG_ADDR_W-1:0] idx;
  } cfgStrobe_t;
endpackage

// File: rtl/sb_cfg_decode.sv
`timescale 1ns/1ps
module sb_cfg_decode #(
  parameter int NUM_OUT  = 20,
  parameter bit PIPELINE = 1'b1
) (
  input  logic                          cfgWe,
  input  logic [sb_pkg::CFG_ADDR_W-1:0] cfgAddr,
  output sb_pkg::cfgStrobe_t            strobe
);
  localparam logic [sb_pkg::CFG_ADDR_W:0] ROUTE_END = (sb_pkg::CFG_ADDR_W+1)'(NUM_OUT);
  localparam logic [sb_pkg::CFG_ADDR_W:0] MODE_END  = (sb_pkg::CFG_ADDR_W+1)'(2*NUM_OUT);

  logic [sb_pkg::CFG_ADDR_W:0] addrExt;
  logic inRoute, inMode;

  always_comb begin
    addrExt = {1'b0, cfgAddr};
    inRoute = addrExt < ROUTE_END;
    inMode  = PIPELINE && !inRoute && (addrExt < MODE_END);
    strobe.hitRoute = inRoute;
    strobe.hitMode  = inMode;
    strobe.routeWe  = cfgWe && inRoute;
    strobe.modeWe   = cfgWe && inMode;
    strobe.idx      = inMode ? sb_pkg::CFG_ADDR_W'(addrExt - ROUTE_END) : cfgAddr;
  end
endmodule

// File: rtl/sb_route_path.sv
`timescale 1ns/1ps
module sb_route_path #(
  parameter int NUM_TRACKS = 5,
  parameter int DATA_W     = 16,
  parameter bit PIPELINE   = 1'b1
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  sb_pkg::cfgStrobe_t               strobe,
  input  logic [sb_pkg::SEL_W-1:0]         wrVal,
  output logic [sb_pkg::SEL_W-1:0]         rdVal,
  input  logic [4*NUM_TRACKS*DATA_W-1:0]   sbIn,
  output logic [4*NUM_TRACKS*DATA_W-1:0]   sbOut
);
  localparam int NUM_OUT = sb_pkg::NUM_SIDES * NUM_TRACKS;
  localparam int IDX_W   = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1;

  logic [sb_pkg::SEL_W-1:0] routeSelArr [NUM_OUT];
  logic                     modeSelArr  [NUM_OUT];

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_lane
    localparam int SIDE  = o / NUM_TRACKS;
    localparam int TRK   = o % NUM_TRACKS;
    localparam int SRC0  = ((SIDE > 0) ? 0 : 1) * NUM_TRACKS + TRK;
    localparam int SRC1  = ((SIDE > 1) ? 1 : 2) * NUM_TRACKS + TRK;
    localparam int SRC2  = ((SIDE > 2) ? 2 : 3) * NUM_TRACKS + TRK;

    logic [sb_pkg::SEL_W-1:0] routeSel;
    logic [DATA_W-1:0]        routed;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        routeSel <= '0;
      else if (strobe.routeWe && strobe.idx == sb_pkg::CFG_ADDR_W'(o))
        routeSel <= wrVal;
    end
    assign routeSelArr[o] = routeSel;

    always_comb begin
      case (routeSel)
        2'd0:    routed = sbIn[SRC0*DATA_W +: DATA_W];
        2'd1:    routed = sbIn[SRC1*DATA_W +: DATA_W];
        2'd2:    routed = sbIn[SRC2*DATA_W +: DATA_W];
        default: routed = '0;
      endcase
    end

    if (PIPELINE) begin : g_pipe
      logic              modeSel;
      logic [DATA_W-1:0] pipeReg;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          modeSel <= 1'b0;
        else if (strobe.modeWe && strobe.idx == sb_pkg::CFG_ADDR_W'(o))
          modeSel <= wrVal[0];
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipeReg <= '0;
        else       pipeReg <= routed;
      end

      assign modeSelArr[o]               = modeSel;
      assign sbOut[o*DATA_W +: DATA_W]   = modeSel ? pipeReg : routed;
    end else begin : g_direct
      assign modeSelArr[o]               = 1'b0;
      assign sbOut[o*DATA_W +: DATA_W]   = routed;
    end
  end

  always_comb begin
    rdVal = '0;
    if (strobe.hitRoute)
      rdVal = routeSelArr[strobe.idx[IDX_W-1:0]];
    else if (strobe.hitMode)
      rdVal = {1'b0, modeSelArr[strobe.idx[IDX_W-1:0]]};
  end
endmodule

// File: rtl/sb_disjoint_switch.sv
`timescale 1ns/1ps
module sb_disjoint_switch #(
  parameter int NUM_TRACKS = 5,
  parameter int DATA_W     = 16,
  parameter bit PIPELINE   = 1'b1
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               cfgWe,
  input  logic [sb_pkg::CFG_ADDR_W-1:0]      cfgAddr,
  input  logic [sb_pkg::CFG_DATA_W-1:0]      cfgWdata,
  output logic [sb_pkg::CFG_DATA_W-1:0]      cfgRdata,
  input  logic [4*NUM_TRACKS*DATA_W-1:0]     sbIn,
  output logic [4*NUM_TRACKS*DATA_W-1:0]     sbOut
);
  localparam int NUM_OUT = sb_pkg::NUM_SIDES * NUM_TRACKS;

  sb_pkg::cfgStrobe_t        strobe;
  logic [sb_pkg::SEL_W-1:0]  rdVal;

  sb_cfg_decode #(.NUM_OUT(NUM_OUT), .PIPELINE(PIPELINE)) u_decode (
    .cfgWe  (cfgWe),
    .cfgAddr(cfgAddr),
    .strobe (strobe)
  );

  sb_route_path #(.NUM_TRACKS(NUM_TRACKS), .DATA_W(DATA_W), .PIPELINE(PIPELINE)) u_path (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .wrVal (cfgWdata[sb_pkg::SEL_W-1:0]),
    .rdVal (rdVal),
    .sbIn  (sbIn),
    .sbOut (sbOut)
  );

  assign cfgRdata = {{(sb_pkg::CFG_DATA_W-sb_pkg::SEL_W){1'b0}}, rdVal};
endmodule

// File: rtl/sb_disjoint_checker.sv
`timescale 1ns/1ps
module sb_disjoint_checker #(
  parameter int NUM_TRACKS = 5,
  parameter int DATA_W     = 16,
  parameter bit PIPELINE   = 1'b1
) (
  input logic                           clk,
  input logic                           rstN,
  input logic                           cfgWe,
  input logic [sb_pkg::CFG_ADDR_W-1:0]  cfgAddr,
  input logic [sb_pkg::CFG_DATA_W-1:0]  cfgWdata,
  input logic [sb_pkg::CFG_DATA_W-1:0]  cfgRdata
);
  localparam int NUM_OUT = 4 * NUM_TRACKS;
  localparam logic [sb_pkg::CFG_ADDR_W:0] ROUTE_END = (sb_pkg::CFG_ADDR_W+1)'(NUM_OUT);
  localparam logic [sb_pkg::CFG_ADDR_W:0] MAP_END   =
    (sb_pkg::CFG_ADDR_W+1)'(PIPELINE ? 2*NUM_OUT : NUM_OUT);

  logic [sb_pkg::CFG_ADDR_W:0] addrExt;
  assign addrExt = {1'b0, cfgAddr};

  // R1: one cycle after a reset edge, everything reads back zero
  a_r1_reset_clears: assert property (@(posedge clk)
    !rstN |=> (cfgRdata == '0));

  // R8: unmapped addresses read zero
  a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rstN)
    (addrExt >= MAP_END) |-> (cfgRdata == '0));

  // R6 and R9: a route write is visible on readback right after the edge
  a_r6_route_readback: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && addrExt < ROUTE_END) |=>
      ((cfgAddr != $past(cfgAddr)) ||
       (cfgRdata == {30'd0, $past(cfgWdata[1:0])})));

  // R6: the upper readback bits never carry data
  a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    cfgRdata[sb_pkg::CFG_DATA_W-1:sb_pkg::SEL_W] == '0);

  if (PIPELINE) begin : g_mode_chk
    // R7: a mode write reads back its bit 0
    a_r7_mode_readback: assert property (@(posedge clk) disable iff (!rstN)
      (cfgWe && addrExt >= ROUTE_END && addrExt < MAP_END) |=>
        ((cfgAddr != $past(cfgAddr)) ||
         (cfgRdata == {31'd0, $past(cfgWdata[0])})));
  end
endmodule

bind sb_disjoint_switch sb_disjoint_checker #(
  .NUM_TRACKS(NUM_TRACKS), .DATA_W(DATA_W), .PIPELINE(PIPELINE)
) u_checker (
  .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
  .cfgWdata(cfgWdata), .cfgRdata(cfgRdata)
);

// File: tb/sb_disjoint_switch_bench.sv
`timescale 1ns/1ps
module sb_disjoint_switch_bench;
  localparam int T    = 5;
  localparam int W    = 16;
  localparam int NOUT = 4 * T;
  localparam int VW   = NOUT * W;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgWe = 1'b0;
  logic [7:0]    cfgAddr = '0;
  logic [31:0]   cfgWdata = '0;
  logic [31:0]   cfgRdata;
  logic [VW-1:0] sbIn = '0;
  logic [VW-1:0] sbOut;

  int testCount = 0;
  int failCount = 0;
  bit finished  = 0;

  int          mRoute [NOUT];
  int          mMode  [NOUT];
  logic [W-1:0] mReg  [NOUT];

  always #2 clk = ~clk;

  sb_disjoint_switch #(.NUM_TRACKS(T), .DATA_W(W), .PIPELINE(1'b1)) u_sb_disjoint_switch (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata), .cfgRdata(cfgRdata), .sbIn(sbIn), .sbOut(sbOut)
  );

  function automatic logic [W-1:0] routedOf(int o);
    int side = o / T;
    int trk  = o % T;
    int k    = mRoute[o];
    int src;
    if (k == 3) return '0;
    src = (k < side) ? k : k + 1;
    return sbIn[(src*T + trk)*W +: W];
  endfunction

  function automatic logic [VW-1:0] expOut();
    logic [VW-1:0] v;
    for (int o = 0; o < NOUT; o++)
      v[o*W +: W] = (mMode[o] != 0) ? mReg[o] : routedOf(o);
    return v;
  endfunction

  function automatic logic [31:0] expRd(int a);
    if (a < NOUT)   return 32'(mRoute[a]);
    if (a < 2*NOUT) return 32'(mMode[a-NOUT]);
    return 32'd0;
  endfunction

  task automatic chkWord(string req, logic [31:0] act, logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chkVec(string req, logic [VW-1:0] act, logic [VW-1:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Advance one edge: update model registers and apply any write, then park at negedge
  task automatic step();
    @(posedge clk);
    for (int o = 0; o < NOUT; o++) mReg[o] = routedOf(o);
    if (cfgWe) begin
      if (cfgAddr < NOUT)        mRoute[cfgAddr] = int'(cfgWdata & 32'd3);
      else if (cfgAddr < 2*NOUT) mMode[cfgAddr-NOUT] = int'(cfgWdata & 32'd1);
    end
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic writeCfg(int a, logic [31:0] d);
    cfgWe = 1'b1; cfgAddr = 8'(a); cfgWdata = d;
    step();
  endtask

  function automatic logic [VW-1:0] randVec();
    logic [VW-1:0] v;
    for (int i = 0; i < VW; i += 32) v[i +: 32] = $urandom;
    return v;
  endfunction

  task automatic readAll(string req);
    for (int a = 0; a < 2*NOUT + 4; a++) begin
      cfgAddr = 8'(a); #0.2;
      chkWord(req, cfgRdata, expRd(a));
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      testCount++; failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] held;
    void'($urandom(32'd1234));
    for (int o = 0; o < NOUT; o++) begin mRoute[o] = 0; mMode[o] = 0; mReg[o] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: everything zero after reset; R4: direct route follows input at once
    readAll("R1 reset readback");
    sbIn = randVec(); #0.5;
    chkVec("R1 R4 default route", sbOut, expOut());
    sbIn = randVec(); #0.5;
    chkVec("R4 same-cycle follow", sbOut, expOut());

    // R6: only bits [1:0] are kept
    writeCfg(7, 32'hFFFF_FFFE);
    cfgAddr = 8'd7; #0.2;
    chkWord("R6 route readback", cfgRdata, 32'd2);
    chkWord("R9 write visible after edge", cfgRdata, expRd(7));

    // R3: select 3 zeroes north track 0
    writeCfg(0, 32'd3);
    sbIn = randVec(); #0.5;
    chkWord("R3 zero lane", 32'(sbOut[0 +: W]), 32'd0);
    chkVec("R3 full vector", sbOut, expOut());

    // R2/R6 map: west track 1 is lane 16; select 1 -> south (side 1) track 1
    writeCfg(3*T + 1, 32'd1);
    sbIn = randVec(); #0.5;
    chkWord("R2 west t1 from south", 32'(sbOut[16*W +: W]), 32'(sbIn[(1*T+1)*W +: W]));
    // R2: east track 2 (lane 12), select 2 -> west track 2
    writeCfg(2*T + 2, 32'd2);
    #0.5;
    chkWord("R2 east t2 from west", 32'(sbOut[12*W +: W]), 32'(sbIn[(3*T+2)*W +: W]));

    // R7: mode bit for lane 16, then R5: registered behaviour
    writeCfg(NOUT + 16, 32'hFFFF_FFFF);
    cfgAddr = 8'(NOUT + 16); #0.2;
    chkWord("R7 mode readback", cfgRdata, 32'd1);
    sbIn = randVec();
    held = sbIn[(1*T+1)*W +: W];
    step();
    sbIn = randVec(); #0.5;
    chkWord("R5 one-cycle delay", 32'(sbOut[16*W +: W]), 32'(held));
    chkVec("R5 full vector", sbOut, expOut());

    // R8: unmapped writes change nothing, read zero
    writeCfg(200, 32'hFFFF_FFFF);
    writeCfg(2*NOUT, 32'h3);
    readAll("R8 unmapped write ignored");
    cfgAddr = 8'd200; #0.2;
    chkWord("R8 unmapped reads zero", cfgRdata, 32'd0);
    #0.3;
    chkVec("R8 outputs unchanged", sbOut, expOut());

    // Random mix covering R2 R4 R5 R6 R7 R9
    for (int c = 0; c < 600; c++) begin
      sbIn     = randVec();
      cfgWe    = ($urandom % 3) == 0;
      cfgAddr  = 8'($urandom % (2*NOUT + 6));
      cfgWdata = $urandom;
      #0.5;
      chkVec("R2 R4 R5 random outputs", sbOut, expOut());
      chkWord("R6 R7 random readback", cfgRdata, expRd(int'(cfgAddr)));
      step();
    end

    // R1: reset in the middle of use clears everything
    rstN = 1'b0;
    for (int o = 0; o < NOUT; o++) begin mRoute[o] = 0; mMode[o] = 0; mReg[o] = '0; end
    #0.5;
    readAll("R1 mid-run reset");
    rstN = 1'b1;

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule